// File: doc/BRIEF.md
# Urgency-Driven Context Swap Controller

This block sits beside the front end of a core that holds two hardware thread contexts, only one of which runs at a time. Each context carries a 3-bit urgency score in the range 0 to 7, which moves with what happens to that thread. A thread making ordinary progress sits at 5. Each blocking long-latency miss lowers it by one. The return of the missed data puts it back at 5. An interrupt aimed at the thread raises it to 6. A fairness timer that runs out while the thread waits in the background lifts it to 7.

The controller asks for a context swap in two cases. The first is when the running thread's score is strictly below the waiting thread's score. The second is when the running thread executes a swap hint, takes a synchronization fault or enters a low-power state. A swap is a short sequence: the request, then a one-cycle pipeline flush, then the foreground identifier flips. The pipeline, the caches and the storage of context state are outside this block.

Top module: `tsc_switch_ctrl`

## Requirements
- R1: After reset the foreground identifier is 0, flush is low, both urgencies are 5 and both fairness timers are cleared, so no swap is requested while the inputs are idle.
- R2: A miss strobe lowers that thread's urgency by one in the next cycle. At 0 it stays at 0 and does not wrap to 7.
- R3: A data-return strobe sets that thread's urgency to 5 in the next cycle.
- R4: An interrupt strobe sets that thread's urgency to 6 in the next cycle.
- R5: A background thread's fairness timer counts each cycle it waits. After TIMEOUT_CYC cycles in the background it expires, and the thread's urgency becomes 7 in the next cycle. Starting from reset with idle inputs, a swap is requested in the TIMEOUT_CYC-th cycle after reset is released.
- R6: When several events hit one thread in the same cycle, the highest one wins. The order is timeout, then interrupt, then data return, then miss.
- R7: switch_req_o is high in the same cycle whenever no flush is in progress and the foreground urgency is strictly below the background urgency.
- R8: A swap hint, a synchronization fault or a low-power entry strobe raises switch_req_o in the same cycle when no flush is in progress.
- R9: One cycle after switch_req_o, flush_o is high for exactly one cycle. fg_id_o flips in the cycle after the flush and changes at no other time. While flush_o is high, switch_req_o stays low and forced strobes are dropped.
- R10: A forced strobe and a winning urgency comparison in the same cycle produce a single swap with a single flush pulse.
- R11: At the swap, the incoming thread's urgency drops to 5 if it is above 5 and no event hits that thread in the flush cycle. Its fairness timer is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_i | input | 2 | Per-thread blocking long-latency miss strobe |
| fill_i | input | 2 | Per-thread miss data-return strobe |
| irq_i | input | 2 | Per-thread external interrupt strobe |
| hint_i | input | 1 | Swap-hint instruction from the foreground thread |
| sync_fault_i | input | 1 | Synchronization fault in the foreground thread |
| sleep_i | input | 1 | Foreground thread enters a low-power state |
| switch_req_o | output | 1 | Swap decision for this cycle |
| flush_o | output | 1 | One-cycle pipeline flush pulse |
| fg_id_o | output | 1 | Identifier of the foreground context |

## Verification
The swap decision is tried with one-sided misses on the running thread, which must swap, and misses on the waiting thread, which must not. It is also tried with strobe pairs on a single thread, where the result tells the event priority apart, and with a run of misses long enough to show whether the counter wraps. Idle stretches long enough for the fairness timer to expire show whether the count is one cycle early or late. Forced strobes placed inside the flush cycle, or together with a winning comparison, separate a design that drops or merges them from one that swaps twice. A miss on the incoming thread right after a swap shows whether its raised score was brought back to nominal.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int NCTX    = 2;
  localparam int URG_W   = 3;

  typedef logic [URG_W-1:0] urg_t;

  localparam urg_t URG_TOP = urg_t'(7);
  localparam urg_t URG_IRQ = urg_t'(6);
  localparam urg_t URG_NOM = urg_t'(5);

  // Next urgency of one thread; the argument order is the priority order.
  function automatic urg_t urg_next(urg_t cur, logic tout, logic irq,
                                    logic ret, logic miss, logic settle);
    urg_t nxt;
    if (tout)                          nxt = URG_TOP;
    else if (irq)                      nxt = URG_IRQ;
    else if (ret)                      nxt = URG_NOM;
    else if (miss)                     nxt = (cur == '0) ? '0 : cur - urg_t'(1);
    else if (settle && cur > URG_NOM)  nxt = URG_NOM;
    else                               nxt = cur;
    return nxt;
  endfunction

  // Swap wanted this cycle (before the flush-in-progress gate).
  function automatic logic swap_wanted(urg_t fg_u, urg_t bg_u, logic forced);
    return forced || (fg_u < bg_u);
  endfunction
endpackage

// File: rtl/tsc_urgency_reg.sv
module tsc_urgency_reg
  import tsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tout,
  input  logic irq,
  input  logic ret,
  input  logic miss,
  input  logic settle,
  output urg_t urg
);
  urg_t urg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) urg_q <= URG_NOM;
    else        urg_q <= urg_next(urg_q, tout, irq, ret, miss, settle);
  end

  assign urg = urg_q;
endmodule

// File: rtl/tsc_fair_timer.sv
module tsc_fair_timer #(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic is_fg,
  output logic expire
);
  localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = !is_fg && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr || expire) cnt_q <= '0;
    else                         cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/tsc_swap_seq.sv
module tsc_swap_seq
  import tsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  urg_t urg_fg,
  input  urg_t urg_bg,
  input  logic forced,
  output logic switch_req,
  output logic flush,
  output logic fg
);
  logic flush_q;
  logic fg_q;

  assign switch_req = !flush_q && swap_wanted(urg_fg, urg_bg, forced);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
      fg_q    <= 1'b0;
    end else begin
      flush_q <= switch_req;
      if (flush_q) fg_q <= ~fg_q;
    end
  end

  assign flush = flush_q;
  assign fg    = fg_q;
endmodule

// File: rtl/tsc_switch_ctrl.sv
module tsc_switch_ctrl
  import tsc_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] miss_i,
  input  logic [1:0] fill_i,
  input  logic [1:0] irq_i,
  input  logic       hint_i,
  input  logic       sync_fault_i,
  input  logic       sleep_i,
  output logic       switch_req_o,
  output logic       flush_o,
  output logic       fg_id_o
);
  // Named internal events, brought out for the checker.
  urg_t            urg_q [NCTX];
  logic [NCTX-1:0] tout_w;
  logic [NCTX-1:0] settle_w;
  logic [NCTX-1:0] tclr_w;
  logic            forced_w;
  logic            fg_w;
  logic            flush_w;
  urg_t            urg_fg_w;
  urg_t            urg_bg_w;

  assign forced_w = hint_i | sync_fault_i | sleep_i;
  assign urg_fg_w = urg_q[fg_w];
  assign urg_bg_w = urg_q[~fg_w];

  for (genvar t = 0; t < NCTX; t++) begin : g_ctx
    logic is_fg;
    assign is_fg       = (fg_w == 1'(t));
    assign settle_w[t] = flush_w && !is_fg;
    assign tclr_w[t]   = is_fg || settle_w[t];

    tsc_fair_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (tclr_w[t]),
      .is_fg  (is_fg),
      .expire (tout_w[t])
    );

    tsc_urgency_reg u_urg (
      .clk    (clk),
      .rst_n  (rst_n),
      .tout   (tout_w[t]),
      .irq    (irq_i[t]),
      .ret    (fill_i[t]),
      .miss   (miss_i[t]),
      .settle (settle_w[t]),
      .urg    (urg_q[t])
    );
  end

  tsc_swap_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .urg_fg     (urg_fg_w),
    .urg_bg     (urg_bg_w),
    .forced     (forced_w),
    .switch_req (switch_req_o),
    .flush      (flush_w),
    .fg         (fg_w)
  );

  assign flush_o = flush_w;
  assign fg_id_o = fg_w;
endmodule

// File: rtl/tsc_switch_ctrl_chk.sv
module tsc_switch_ctrl_chk
  import tsc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       switch_req,
  input logic       flush,
  input logic       fg,
  input urg_t       urg0,
  input urg_t       urg1,
  input logic [1:0] tout,
  input logic [1:0] miss,
  input logic [1:0] ret,
  input logic [1:0] irq,
  input logic       forced
);
  assert_flush_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);
  assert_req_then_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    switch_req |=> flush);
  assert_fg_flips_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fg != $past(fg)));
  assert_fg_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (fg == $past(fg)));
  assert_single_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !switch_req);
  assert_forced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (forced && !flush) |-> switch_req);
  assert_compare_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && ((fg ? urg1 : urg0) < (fg ? urg0 : urg1))) |-> switch_req);
  assert_timeout_lvl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tout[0] |=> (urg0 == 3'd7));
  assert_irq_lvl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq[1] && !tout[1]) |=> (urg1 == 3'd6));
  assert_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (urg1 == 3'd0 && miss[1] && !ret[1] && !irq[1] && !tout[1]) |=> (urg1 == 3'd0));
  assert_fill_lvl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret[0] && !irq[0] && !tout[0]) |=> (urg0 == 3'd5));
endmodule

bind tsc_switch_ctrl tsc_switch_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .switch_req (switch_req_o),
  .flush      (flush_o),
  .fg         (fg_id_o),
  .urg0       (urg_q[0]),
  .urg1       (urg_q[1]),
  .tout       (tout_w),
  .miss       (miss_i),
  .ret        (fill_i),
  .irq        (irq_i),
  .forced     (forced_w)
);

// File: tb/tsc_switch_ctrl_test.sv
`timescale 1ns/1ps
module tsc_switch_ctrl_test;
  localparam int LIM = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] miss = '0, fill = '0, irq = '0;
  logic       hint = 1'b0, sfault = 1'b0, sleep = 1'b0;
  logic       req, flush, fg;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  tsc_switch_ctrl #(.TIMEOUT_CYC(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .miss_i(miss), .fill_i(fill), .irq_i(irq),
    .hint_i(hint), .sync_fault_i(sfault), .sleep_i(sleep),
    .switch_req_o(req), .flush_o(flush), .fg_id_o(fg)
  );

  // Behavioural reference: scores, wait counts, foreground, flush flag.
  int mu [2];
  int mc [2];
  int mfg;
  int mfl;

  function automatic int want_req();
    int f;
    f = (hint || sfault || sleep) ? 1 : 0;
    if (mu[mfg] < mu[1-mfg]) f = 1;
    return (mfl == 0) ? f : 0;
  endfunction

  always @(posedge clk) begin
    int nu [2];
    int nc [2];
    int nreq;
    if (!rst_n) begin
      mu[0] = 5; mu[1] = 5; mc[0] = 0; mc[1] = 0; mfg = 0; mfl = 0;
    end else begin
      nreq = want_req();
      for (int t = 0; t < 2; t++) begin
        bit tout, incoming;
        tout     = (t != mfg) && (mc[t] == LIM - 1);
        incoming = (mfl != 0) && (t != mfg);
        if (tout)                        nu[t] = 7;
        else if (irq[t])                 nu[t] = 6;
        else if (fill[t])                nu[t] = 5;
        else if (miss[t])                nu[t] = (mu[t] > 0) ? mu[t] - 1 : 0;
        else if (incoming && mu[t] > 5)  nu[t] = 5;
        else                             nu[t] = mu[t];
        nc[t] = (t == mfg || incoming || tout) ? 0 : mc[t] + 1;
      end
      if (mfl != 0) mfg = 1 - mfg;
      mfl = nreq;
      mu = nu;
      mc = nc;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 switch_req vs model", int'(req), want_req());
      chk("R9 flush vs model", int'(flush), mfl);
      chk("R9 fg vs model", int'(fg), mfg);
    end
  end

  task automatic nxt();
    @(posedge clk);
    #1;
    miss = '0; fill = '0; irq = '0; hint = 1'b0; sfault = 1'b0; sleep = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk);
    #1 rst_n = 1'b0;
    miss = '0; fill = '0; irq = '0; hint = 1'b0; sfault = 1'b0; sleep = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int first;
    int pulses;

    // R1: reset state
    do_reset();
    @(negedge clk);
    chk("R1 fg after reset", int'(fg), 0);
    chk("R1 flush after reset", int'(flush), 0);
    chk("R1 no request idle", int'(req), 0);

    // R2: miss on the running thread lowers it below the waiting one
    do_reset();
    nxt(); miss = 2'b01;
    nxt(); @(negedge clk);
    chk("R2 miss on fg drives swap", int'(req), 1);
    nxt(); @(negedge clk);
    chk("R9 flush follows request", int'(flush), 1);
    chk("R9 fg held during flush", int'(fg), 0);
    nxt(); @(negedge clk);
    chk("R9 flush is one cycle", int'(flush), 0);
    chk("R9 fg flipped", int'(fg), 1);

    // R2: floor at zero, no wrap
    do_reset();
    for (int i = 0; i < 6; i++) begin
      nxt(); miss = 2'b10;
    end
    nxt(); @(negedge clk);
    chk("R2 background urgency floors at 0", int'(req), 0);

    // R3: data return restores nominal
    do_reset();
    nxt(); miss = 2'b10;
    nxt(); fill = 2'b10;
    nxt(); miss = 2'b01;
    nxt(); @(negedge clk);
    chk("R3 return restores 5", int'(req), 1);

    // R4: interrupt raises to 6
    do_reset();
    nxt(); irq = 2'b10;
    nxt(); @(negedge clk);
    chk("R4 interrupt on background", int'(req), 1);

    // R6: priority among same-cycle events
    do_reset();
    nxt(); irq = 2'b10; miss = 2'b10;
    nxt(); @(negedge clk);
    chk("R6 interrupt beats miss", int'(req), 1);
    do_reset();
    nxt(); fill = 2'b01; miss = 2'b01;
    nxt(); @(negedge clk);
    chk("R6 return beats miss", int'(req), 0);

    // R5: fairness timeout
    do_reset();
    first = 0;
    for (int i = 1; i <= 2 * LIM; i++) begin
      nxt(); @(negedge clk);
      if (req && first == 0) first = i;
    end
    chk("R5 first timeout request cycle", first, LIM);
    chk("R5 swapped to waiting thread", int'(fg), 1);

    // R8: forced strobes
    do_reset();
    nxt(); sfault = 1'b1; @(negedge clk);
    chk("R8 sync fault forces swap", int'(req), 1);
    do_reset();
    nxt(); sleep = 1'b1; @(negedge clk);
    chk("R8 low-power entry forces swap", int'(req), 1);
    do_reset();
    nxt(); hint = 1'b1; @(negedge clk);
    chk("R8 hint forces swap", int'(req), 1);
    // R9: hint inside flush cycle is dropped
    nxt(); hint = 1'b1; @(negedge clk);
    chk("R9 no request while flushing", int'(req), 0);
    nxt(); @(negedge clk);
    chk("R9 dropped hint gives no flush", int'(flush), 0);
    chk("R9 fg after hint swap", int'(fg), 1);
    nxt(); @(negedge clk);
    chk("R9 still no second flush", int'(flush), 0);

    // R10: forced and comparison together -> one swap
    do_reset();
    nxt(); hint = 1'b1; miss = 2'b01;
    pulses = 0;
    for (int i = 0; i < 6; i++) begin
      nxt(); @(negedge clk);
      if (flush) pulses++;
    end
    chk("R10 single flush pulse", pulses, 1);
    chk("R10 single fg flip", int'(fg), 1);

    // R11: incoming thread settles to nominal
    do_reset();
    nxt(); irq = 2'b10;
    nxt();
    nxt();
    nxt(); miss = 2'b10;
    nxt(); @(negedge clk);
    chk("R11 incoming urgency settled to 5", int'(req), 1);

    nxt();
    nxt();
    finish_run();
  end
endmodule